// File: doc/BRIEF.md
# Carry Select Adder with Increment Conversion

This block adds two unsigned operands and a carry-in, and returns the sum and a carry-out, with no clock and no latency. The operand width is cut into slices. Each slice adds its bits once, with a ripple chain that assumes no carry comes in. An incrementer then adds one to that slice result, including the slice's own carry bit, to give the result for the case where a carry does come in. So no slice needs a second ripple chain. When the true carry reaches the slice, a two-way selector picks one of the two results. The only serial path that crosses slice boundaries is the chain of selectors.

The first slice has its own width parameter and every later slice shares a second width parameter. The top slice may be narrower when the widths do not divide evenly. The default is 8 bits as two 4-bit slices. A 2-bit slice followed by a 6-bit slice is the other split in common use. Every slice works the same way, the lowest one included. Its least significant position is a half adder because the assumed carry is zero, and the external carry-in drives its selector. The block has no valid/ready handshake, because it holds no state and never stalls. The operands are presented and the result is read in the same cycle.

Top module: `csel_inc_adder`

## Requirements
- R1: Inside each slice, the ripple chain gives the slice's operand bits added with no carry-in, as a sum and a carry bit one position wider than the slice.
- R2: The incrementer of a slice outputs its (width+1)-bit input plus one, modulo 2^(width+1). Bit 0 is the inverse of input bit 0, and bit k is input bit k XOR the AND of all lower input bits.
- R3: A slice whose incoming carry is 0 outputs the direct ripple result. A slice whose incoming carry is 1 outputs the incremented result.
- R4: The carry into the lowest slice is the external carry-in. The carry into every other slice is the selected carry of the slice below it.
- R5: `cout` equals bit WIDTH of A+B+cin, which is the selected carry of the top slice.
- R6: `sum` equals (A+B+cin) modulo 2^WIDTH for every operand pair and both carry-in values.
- R7: The slice split changes the structure but not the result: FIRST_W=2 with REST_W=6 gives the same outputs as the default 4+4 split.
- R8: The outputs follow an input change within the same cycle; no register lies on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench goes after carries that must cross a slice boundary through the incrementer path, for example an all-ones lower slice combined with carry-in 1. An incrementer that left out the slice's carry bit would give the wrong top carry-out there. It also covers the full wrap from all ones plus one, where a design with a broken increment chain would return a non-zero sum or drop cout. Every operand pair is run against a behavioural sum under both carry-in values and for both slice splits. A selector wired to the wrong carry, or a half adder placed where a full adder belongs, therefore shows up as a wrong sum on some vector.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Bit offset of slice g.
  function automatic int slice_lo(int g, int first_w, int rest_w);
    return (g == 0) ? 0 : first_w + (g - 1) * rest_w;
  endfunction

  // Width of slice g, with the top slice clipped to the total width.
  function automatic int slice_w(int g, int width, int first_w, int rest_w);
    int lo;
    int hi;
    lo = slice_lo(g, first_w, rest_w);
    hi = (g == 0) ? first_w : lo + rest_w;
    if (hi > width) hi = width;
    return hi - lo;
  endfunction

  function automatic int slice_count(int width, int first_w, int rest_w);
    if (width <= first_w) return 1;
    return 1 + (width - first_w + rest_w - 1) / rest_w;
  endfunction
endpackage

// File: rtl/zero_carry_ripple.sv
module zero_carry_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;

  assign c[0] = 1'b0;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_half
        // assumed carry is zero: half adder
        assign s[i]   = x[i] ^ y[i];
        assign c[i+1] = x[i] & y[i];
      end else begin : g_full
        assign s[i]   = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
      end
    end
  endgenerate

  assign co = c[W];

  always_comb begin
    a_r1_slice_sum : assert ({co, s} == ({1'b0, x} + {1'b0, y}))
      else $error("slice ripple sum mismatch");
  end
endmodule

// File: rtl/excess_one_conv.sv
module excess_one_conv #(
  parameter int N = 5
) (
  input  logic [N-1:0] v,
  output logic [N-1:0] v_inc
);
  generate
    for (genvar k = 0; k < N; k++) begin : g_bit
      if (k == 0) begin : g_lsb
        assign v_inc[k] = ~v[k];
      end else begin : g_up
        assign v_inc[k] = v[k] ^ (&v[k-1:0]);
      end
    end
  endgenerate

  always_comb begin
    a_r2_plus_one : assert (v_inc == N'(v + N'(1)))
      else $error("increment converter mismatch");
  end
endmodule

// File: rtl/slice_pick.sv
module slice_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] s_direct,
  input  logic         c_direct,
  input  logic [W:0]   r_inc,
  input  logic         carry_in,
  output logic [W-1:0] s_out,
  output logic         c_out
);
  always_comb begin
    if (carry_in) begin
      s_out = r_inc[W-1:0];
      c_out = r_inc[W];
    end else begin
      s_out = s_direct;
      c_out = c_direct;
    end
  end

  // a carry in can never take away a carry out
  always_comb begin
    a_r3_carry_monotone : assert (!(c_direct && !r_inc[W] && carry_in) || c_out)
      else $error("selected carry lost");
  end
endmodule

// File: rtl/csel_inc_adder.sv
module csel_inc_adder
  import csel_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int FIRST_W = 4,
  parameter int REST_W  = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSL = slice_count(WIDTH, FIRST_W, REST_W);

  logic [NSL:0] sc;

  assign sc[0] = cin;

  generate
    for (genvar g = 0; g < NSL; g++) begin : g_slice
      localparam int LO = slice_lo(g, FIRST_W, REST_W);
      localparam int SW = slice_w(g, WIDTH, FIRST_W, REST_W);

      logic [SW-1:0] s0;
      logic          c0;
      logic [SW:0]   r1;
      logic [SW-1:0] s_sel;
      logic          c_sel;

      zero_carry_ripple #(.W(SW)) u_ripple (
        .x  (a[LO +: SW]),
        .y  (b[LO +: SW]),
        .s  (s0),
        .co (c0)
      );

      excess_one_conv #(.N(SW + 1)) u_inc (
        .v     ({c0, s0}),
        .v_inc (r1)
      );

      slice_pick #(.W(SW)) u_pick (
        .s_direct (s0),
        .c_direct (c0),
        .r_inc    (r1),
        .carry_in (sc[g]),
        .s_out    (s_sel),
        .c_out    (c_sel)
      );

      assign sum[LO +: SW] = s_sel;
      assign sc[g+1]       = c_sel;
    end
  endgenerate

  assign cout = sc[NSL];

  always_comb begin
    a_r6_total_sum : assert (sum == WIDTH'({1'b0, a} + {1'b0, b} + (WIDTH + 1)'(cin)))
      else $error("sum mismatch");
    a_r5_carry_out : assert (cout == (({1'b0, a} + {1'b0, b} + (WIDTH + 1)'(cin)) >> WIDTH))
      else $error("carry-out mismatch");
  end
endmodule

// File: tb/test_csel_inc_adder.sv
module test_csel_inc_adder;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] s_def, s_alt;
  logic         co_def, co_alt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  csel_inc_adder #(.WIDTH(W)) i_csel_inc_adder (
    .a(a), .b(b), .cin(cin), .sum(s_def), .cout(co_def)
  );

  csel_inc_adder #(.WIDTH(W), .FIRST_W(2), .REST_W(6)) i_csel_inc_adder_alt (
    .a(a), .b(b), .cin(cin), .sum(s_alt), .cout(co_alt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0h b=%0h cin=%0d actual=%0h expected=%0h", req, a, b, cin, act, exp);
    end
  endtask

  // drive after a rising edge, sample at the next falling edge
  task automatic apply(input int x, input int y, input int c);
    @(posedge clk);
    a   = W'(x);
    b   = W'(y);
    cin = c[0];
    @(negedge clk);
  endtask

  task automatic full_check(input string req, input int x, input int y, input int c);
    int ref_total;
    apply(x, y, c);
    ref_total = x + y + c;
    check(req, int'(s_def), ref_total % 256);
    check(req, int'(co_def), ref_total / 256);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset sum", int'(s_def), 0);
    check("R5 reset cout", int'(co_def), 0);
    rst_n = 1'b1;

    full_check("R1 plain slices", 8'h12, 8'h34, 0);
    full_check("R4 ripple carry crosses slice", 8'h08, 8'h08, 0);
    full_check("R3 incremented path crosses slice", 8'h0F, 8'h00, 1);
    full_check("R3 upper incremented", 8'h1F, 8'h00, 1);
    full_check("R2 full wrap", 8'hFF, 8'h00, 1);
    full_check("R2 converter carry bit", 8'hF8, 8'h08, 1);
    full_check("R5 top carry", 8'h80, 8'h80, 0);
    // same-cycle response to a fresh change
    full_check("R8 same cycle", 8'h01, 8'h01, 0);
    full_check("R8 same cycle follow", 8'hAA, 8'h55, 1);

    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          int ref_total;
          apply(x, y, c);
          ref_total = x + y + c;
          check("R6 sum", int'(s_def), ref_total % 256);
          check("R5 cout", int'(co_def), ref_total / 256);
          check("R7 split 2+6", int'({co_alt, s_alt}), ref_total);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule